// File: doc/BRIEF.md
# Frame-Delimited SPI Slave Port

This block is the receive-and-transmit side of a serial peripheral interface that acts only as a slave. It runs on the system clock and treats the external serial clock, data-in and select lines as asynchronous signals: each passes through a synchronizer, and the block finds serial-clock edges by comparing successive synchronized samples. A transfer is framed by the select line. It starts when the external master pulls select low and ends when select returns high, however many bits were clocked. Bits move most significant first. Incoming data is sampled on the rising serial-clock edge, and outgoing data changes on the falling edge.

Software preloads the outgoing byte by writing the data port between frames. When select rises, whatever the shift register then holds is copied into a receive buffer and a completion flag is raised. If software has not written a new byte before the next frame, the shift register still holds the previously received byte, and that byte is what goes out. A write made while a frame is in progress is refused and flagged as a collision. If a frame ends while the buffer still holds a byte that software has not read, the old byte is kept, the new byte is dropped, and an overrun flag is raised.

Top module: `spis_slave`

## Requirements
- R1: The port takes part in a transfer only while `en`=1 and `master_mode`=0. Otherwise select activity is ignored: no flag is set, `miso_oe` stays 0, and the shift register keeps its contents.
- R2: `miso_oe` is 1 only while the port is active and the synchronized select is low. At all other times it is 0, which means the data-out line is released (high impedance).
- R3: Bits move MSB first. The data-in line is sampled on each rising serial-clock edge, and `miso_o` changes only after a falling serial-clock edge. The first bit (MSB) is presented when select falls. The serial clock idles low.
- R4: `done_flag` is set by the synchronized rising edge of select, whatever number of bits was clocked, and is visible within 3 system clocks of that edge at the pin.
- R5: On that rising edge, if the buffer has been read, `rd_data` takes the last DW bits in the shift register and the buffer is marked unread. After an N-bit frame these bits are the preload shifted left by N, with the N received bits in the low positions.
- R6: A `wr_en` pulse while select is high loads `wr_data` into the shift register, and that value is sent in the next frame.
- R7: If no write happens between two frames, the second frame sends the shift register unchanged, which is the byte received in the first frame.
- R8: A `wr_en` pulse while select is low sets `wcol_flag` on the next clock and is ignored. The transfer in progress continues unchanged.
- R9: When select rises while the buffer is unread, `ovr_flag` is set, `rd_data` keeps the older byte, and the new byte is lost.
- R10: A `rd_en` pulse marks the buffer read. A `clr_flags` pulse clears all three flags. If a flag is set in the same cycle, the set wins.
- R11: After reset all flags are 0, `rd_data` is 0, the shift register is 0 and `miso_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Interface enable |
| master_mode | input | 1 | Master selected; the slave is idle when 1 |
| sck_i | input | 1 | Serial clock from the external master (asynchronous) |
| mosi_i | input | 1 | Serial data in (asynchronous) |
| nss_i | input | 1 | Active-low frame select (asynchronous) |
| miso_o | output | 1 | Serial data out |
| miso_oe | output | 1 | Output enable for the data-out line |
| wr_en | input | 1 | Data-port write strobe |
| wr_data | input | DW | Byte to preload for transmission |
| rd_en | input | 1 | Data-port read strobe; marks the buffer read |
| rd_data | output | DW | Receive buffer |
| clr_flags | input | 1 | Clears done, collision and overrun flags |
| done_flag | output | 1 | Frame complete |
| wcol_flag | output | 1 | Write collision |
| ovr_flag | output | 1 | Receive overrun |

## Verification
The hardest conditions to reach from the ports are the ones where software timing and frame timing overlap. These are a write arriving halfway through a frame, a frame ending on top of an unread byte, and a frame sent with no fresh preload. The bench drives the serial pins itself, several system clocks per half bit, so it can put a write strobe between two chosen serial edges. It can also skip a read before a frame, or skip a preload. It then reads the bytes that come out of `miso_o` and checks them against the byte that should have been left in the shift register. A frame of only four bits shows that the end of a frame follows select and not a bit count.

// File: rtl/spis_pkg.sv
// Shared types for the SPI slave port.
package spis_pkg;
    typedef struct packed {
        logic done;
        logic wcol;
        logic ovr;
    } spis_flags_t;
endpackage

// File: rtl/spis_sync.sv
// Multi-stage synchronizer for a group of asynchronous inputs.
// Assumes the bits are independent; each settles through STAGES flops.
module spis_sync #(
    parameter int         W       = 3,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // Shift each input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/spis_shift.sv
// Shift register and output bit for the slave port.
// Assumes the load and frame-start requests never coincide with clock edges
// of a frame (the top gates loads to idle periods).
module spis_shift #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_en,
    input  logic [DW-1:0] load_data,
    input  logic          frame_start,
    input  logic          sck_rise,
    input  logic          sck_fall,
    input  logic          mosi_s,
    output logic [DW-1:0] sh,
    output logic          miso_q
);
    // Load from software, or shift in one bit per rising serial edge.
    always_ff @(posedge clk) begin
        if (!rst_n)        sh <= '0;
        else if (load_en)  sh <= load_data;
        else if (sck_rise) sh <= {sh[DW-2:0], mosi_s};
    end

    // Present the MSB at frame start, then the next bit after each falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                       miso_q <= 1'b0;
        else if (frame_start || sck_fall) miso_q <= sh[DW-1];
    end
endmodule

// File: rtl/spis_ctrl.sv
// Receive buffer and status flags for the slave port.
// Assumes frame_end is a single-cycle pulse per synchronized select rise.
module spis_ctrl
    import spis_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_end,
    input  logic [DW-1:0] sh,
    input  logic          rd_en,
    input  logic          wr_coll,
    input  logic          clr,
    output logic [DW-1:0] rx_buf,
    output spis_flags_t   flags
);
    logic unread;

    // Capture the shift register at frame end unless a byte is still pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_buf <= '0;
            unread <= 1'b0;
        end else if (frame_end && !unread) begin
            rx_buf <= sh;
            unread <= 1'b1;
        end else if (rd_en) begin
            unread <= 1'b0;
        end
    end

    // Flag update: a set beats a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            if (clr) flags <= '0;
            if (frame_end)           flags.done <= 1'b1;
            if (frame_end && unread) flags.ovr  <= 1'b1;
            if (wr_coll)             flags.wcol <= 1'b1;
        end
    end
endmodule

// File: rtl/spis_slave.sv
// SPI slave port, framed by an active-low select line.
// Samples the serial clock, data and select with the system clock; it assumes
// the system clock is at least several times faster than the serial clock.
module spis_slave
    import spis_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          master_mode,
    input  logic          sck_i,
    input  logic          mosi_i,
    input  logic          nss_i,
    output logic          miso_o,
    output logic          miso_oe,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    input  logic          clr_flags,
    output logic          done_flag,
    output logic          wcol_flag,
    output logic          ovr_flag
);
    localparam int NSYNC = 3;
    localparam logic [NSYNC-1:0] SYNC_RST = 3'b100;

    logic [NSYNC-1:0] sync_q;
    logic             nss_s, sck_s, mosi_s;
    logic             nss_q, sck_q;
    logic             slave_on, active;
    logic             nss_rise, nss_fall, sck_rise, sck_fall;
    logic [DW-1:0]    sh;
    spis_flags_t      flags;

    spis_sync #(.W(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({nss_i, sck_i, mosi_i}), .q(sync_q)
    );
    assign {nss_s, sck_s, mosi_s} = sync_q;

    // Keep the previous synchronized samples for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nss_q <= 1'b1;
            sck_q <= 1'b0;
        end else begin
            nss_q <= nss_s;
            sck_q <= sck_s;
        end
    end

    assign slave_on = en && !master_mode;
    assign active   = slave_on && !nss_s;
    assign nss_rise = slave_on && nss_s && !nss_q;
    assign nss_fall = slave_on && !nss_s && nss_q;
    assign sck_rise = active && sck_s && !sck_q;
    assign sck_fall = active && !sck_s && sck_q;

    spis_shift #(.DW(DW)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .load_en(wr_en && !active), .load_data(wr_data),
        .frame_start(nss_fall), .sck_rise(sck_rise), .sck_fall(sck_fall),
        .mosi_s(mosi_s), .sh(sh), .miso_q(miso_o)
    );

    spis_ctrl #(.DW(DW)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .frame_end(nss_rise), .sh(sh), .rd_en(rd_en),
        .wr_coll(wr_en && active), .clr(clr_flags),
        .rx_buf(rd_data), .flags(flags)
    );

    assign miso_oe   = active;
    assign done_flag = flags.done;
    assign wcol_flag = flags.wcol;
    assign ovr_flag  = flags.ovr;
endmodule

// File: rtl/spis_checker.sv
// Temporal checks on the SPI slave port, attached by bind.
module spis_checker #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          nss_s,
    input logic          sck_s,
    input logic          wr_en,
    input logic          miso_oe,
    input logic          miso_o,
    input logic          done_flag,
    input logic          wcol_flag,
    input logic          ovr_flag,
    input logic [DW-1:0] rd_data
);
    AST_DONE_ON_NSS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> ($past(nss_s) && !$past(nss_s, 2))); // R4
    AST_RXBUF_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_data) |-> ($past(nss_s) && !$past(nss_s, 2))); // R5
    AST_WCOL_ON_BUSY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && miso_oe) |=> wcol_flag); // R8
    AST_OVR_KEEPS_OLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_flag) |-> $stable(rd_data)); // R9
    AST_MISO_HOLD_HIGH_SCK: assert property (@(posedge clk) disable iff (!rst_n)
        (miso_oe && $past(miso_oe) && sck_s && $past(sck_s)) |-> $stable(miso_o)); // R3
endmodule

bind spis_slave spis_checker #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .nss_s(nss_s), .sck_s(sck_s),
    .wr_en(wr_en), .miso_oe(miso_oe), .miso_o(miso_o),
    .done_flag(done_flag), .wcol_flag(wcol_flag), .ovr_flag(ovr_flag),
    .rd_data(rd_data)
);

// File: tb/sim_spis_slave.sv
// Self-checking bench for spis_slave.
module sim_spis_slave;
    logic clk = 1'b0, rst_n = 1'b0;
    logic en = 1'b1, master_mode = 1'b0;
    logic sck = 1'b0, mosi = 1'b0, nss = 1'b1;
    logic miso_o, miso_oe;
    logic wr_en = 1'b0, rd_en = 1'b0, clr_flags = 1'b0;
    logic [7:0] wr_data = '0, rd_data;
    logic done_flag, wcol_flag, ovr_flag;
    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    spis_slave u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .master_mode(master_mode),
        .sck_i(sck), .mosi_i(mosi), .nss_i(nss),
        .miso_o(miso_o), .miso_oe(miso_oe),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .clr_flags(clr_flags), .done_flag(done_flag),
        .wcol_flag(wcol_flag), .ovr_flag(ovr_flag)
    );

    // {preload, mosi byte, expected miso byte, expected received byte}
    localparam logic [31:0] VEC [4] = '{
        32'hA5_3C_A5_3C, 32'h00_FF_00_FF, 32'hFF_00_FF_00, 32'h81_7E_81_7E
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_byte(input logic [7:0] v);
        @(negedge clk); wr_en = 1'b1; wr_data = v;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd_clear();
        @(negedge clk); rd_en = 1'b1; clr_flags = 1'b1;
        @(negedge clk); rd_en = 1'b0; clr_flags = 1'b0;
    endtask

    // One frame of nb bits; optionally a data-port write halfway through.
    task automatic frame(input logic [7:0] mv, input int nb, input bit wr_mid,
                         output logic [7:0] cap, output logic oe_seen);
        cap = '0; oe_seen = 1'b0;
        @(negedge clk); nss = 1'b0;
        repeat (6) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            mosi = mv[nb-1-i];
            repeat (4) @(negedge clk);
            cap = {cap[6:0], miso_o};
            oe_seen = oe_seen | miso_oe;
            if (wr_mid && i == 3) begin
                wr_en = 1'b1; wr_data = 8'hFF;
                @(negedge clk); wr_en = 1'b0;
            end
            sck = 1'b1;
            repeat (4) @(negedge clk);
            sck = 1'b0;
        end
        repeat (4) @(negedge clk);
        nss = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] cap;
        logic oe;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk("R11 done", done_flag, 0);
        chk("R11 wcol", wcol_flag, 0);
        chk("R11 ovr", ovr_flag, 0);
        chk("R11 rd_data", rd_data, 0);
        chk("R11 oe", miso_oe, 0);

        // R3 R5 R6 R2: table-driven full-byte frames
        for (int v = 0; v < 4; v++) begin
            wr_byte(VEC[v][31:24]);
            frame(VEC[v][23:16], 8, 1'b0, cap, oe);
            chk("R3 R6 miso byte", cap, VEC[v][15:8]);
            chk("R5 rx byte", rd_data, VEC[v][7:0]);
            chk("R4 done", done_flag, 1);
            chk("R2 oe during frame", oe, 1);
            chk("R2 oe idle", miso_oe, 0);
            chk("R10 no ovr after read", ovr_flag, 0);
            rd_clear();
            chk("R10 cleared", {done_flag, wcol_flag, ovr_flag}, 0);
        end

        // R7: no preload resends the last received byte (0x7E)
        frame(8'h3C, 8, 1'b0, cap, oe);
        chk("R7 resend", cap, 8'h7E);
        chk("R7 rx", rd_data, 8'h3C);
        rd_clear();

        // R8: write during a frame is flagged and ignored
        wr_byte(8'h81);
        frame(8'h42, 8, 1'b1, cap, oe);
        chk("R8 wcol", wcol_flag, 1);
        chk("R8 miso unchanged", cap, 8'h81);
        chk("R8 rx", rd_data, 8'h42);
        rd_clear();

        // R9: overrun keeps the old byte
        wr_byte(8'h11);
        frame(8'hA5, 8, 1'b0, cap, oe);
        chk("R9 first rx", rd_data, 8'hA5);
        chk("R9 no ovr yet", ovr_flag, 0);
        clr_flags = 1'b1; @(negedge clk); clr_flags = 1'b0;
        frame(8'h5A, 8, 1'b0, cap, oe);
        chk("R9 ovr", ovr_flag, 1);
        chk("R9 old kept", rd_data, 8'hA5);
        chk("R4 done on ovr frame", done_flag, 1);
        rd_clear();

        // R4 R5: a 4-bit frame ends on select, buffer = {pre[3:0], nibble}
        wr_byte(8'hC3);
        frame(8'h09, 4, 1'b0, cap, oe);
        chk("R4 short done", done_flag, 1);
        chk("R5 short rx", rd_data, 8'h39);
        chk("R3 short miso", cap, 8'h0C);
        rd_clear();

        // R1: disabled and master-mode frames are ignored
        en = 1'b0;
        frame(8'hEE, 8, 1'b0, cap, oe);
        chk("R1 en=0 done", done_flag, 0);
        chk("R1 en=0 oe", oe, 0);
        en = 1'b1; master_mode = 1'b1;
        frame(8'hDD, 8, 1'b0, cap, oe);
        chk("R1 master done", done_flag, 0);
        chk("R1 master oe", oe, 0);
        chk("R1 rx kept", rd_data, 8'h39);
        master_mode = 1'b0;
        frame(8'h66, 8, 1'b0, cap, oe);
        chk("R1 shift reg kept", cap, 8'h39);
        chk("R1 rx after enable", rd_data, 8'h66);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule